// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a small Moore state machine that decides when to release one item. Buyers drop coins into a single slot, and the slot reports each coin as a one-cycle pulse. There are only two kinds of coin: a nickel, worth 5 cents, and a dime, worth 10 cents. The price is fixed at 15 cents. The block keeps the credit built up so far. When that credit reaches 15 cents, it raises a release strobe for exactly one cycle and then starts again from zero.

The block never returns change. If a dime arrives while the credit is already 10 cents, the credit stops at 15 cents and the extra 5 cents is lost. The release strobe is decoded from the stored state alone, so it only changes just after a clock edge. The credit is held as a 2-bit register:

| Credit | Code |
|---|---|
| 0 cents | 00 |
| 5 cents | 01 |
| 10 cents | 10 |
| 15 cents | 11 |

Top module: `vendCtrl`

## Requirements
- R1: When `rstN` is low, the credit is cleared to 0 cents at once and `vendOpen` is low. After reset, only a total of 15 cents in new coins raises `vendOpen`.
- R2: A nickel pulse raises the credit by 5 cents on the next rising clock edge. The three steps are 0→5, 5→10 and 10→15.
- R3: A dime pulse raises the credit by 10 cents on the next rising clock edge. The two steps are 0→10 and 5→15.
- R4: A dime pulse at 10 cents credit takes the credit to 15 cents. The extra 5 cents is lost.
- R5: `vendOpen` is high exactly when the stored credit is 15 cents. It depends only on the state, not on the current coin inputs.
- R6: From 15 cents the credit goes back to 0 on the next clock edge. As a result, `vendOpen` is never high for two cycles in a row.
- R7: Coin pulses that arrive in the cycle where the credit is 15 cents have no effect. The credit still goes to 0.
- R8: A nickel and a dime asserted in the same cycle count as no coin. The credit stays where it is.
- R9: In a cycle with no coin pulse, and with the credit below 15 cents, the credit does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| coinNickel | input | 1 | One-cycle pulse: a nickel entered the slot |
| coinDime | input | 1 | One-cycle pulse: a dime entered the slot |
| vendOpen | output | 1 | Release strobe, high while the credit is 15 cents |

## Verification
The assertions check, on every cycle, how the control stage maps coins onto strobes:
- coins are blocked while the credit is full;
- a simultaneous nickel and dime produce no strobe;
- at most one strobe is active at a time.

They also check how the credit register reacts to those strobes:
- a clear leads to zero credit;
- a dime at 10 cents saturates the credit;
- the credit holds when no strobe is active;
- the full state lasts a single cycle.

Only the bench's coin sequences can show the behaviour seen from outside. These include the exact cycle on which release follows each mix of coins, and the fact that a coin swallowed during release does not count toward the next purchase. They also include the credit being truly zero after a reset in the middle of a purchase, which is visible only through later release timing.

// File: rtl/vendCtrlPkg.sv
package vendCtrlPkg;

  // Credit is counted in units of 5 cents.
  localparam int CREDIT_W    = 2;
  localparam int NICKEL_UNIT = 1;
  localparam int DIME_UNIT   = 2;

  typedef logic [CREDIT_W-1:0] credit_t;

  localparam credit_t CREDIT_ZERO = '0;
  localparam credit_t CREDIT_FULL = '1;

  // Strobes sent from the control stage to the credit datapath.
  typedef struct packed {
    logic clear;
    logic addNickel;
    logic addDime;
  } strobe_t;

endpackage

// File: rtl/vendCtrlFsm.sv
module vendCtrlFsm
  import vendCtrlPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    coinNickel,
  input  logic    coinDime,
  input  logic    creditFull,
  output strobe_t strobes
);

  logic coinClash;

  always_comb begin
    coinClash = coinNickel & coinDime;
    strobes   = '0;
    if (creditFull) begin
      // Release cycle: always return to zero and drop any coin.
      strobes.clear = 1'b1;
    end else if (!coinClash) begin
      strobes.addNickel = coinNickel;
      strobes.addDime   = coinDime;
    end
  end

  // R7: coins seen while full must not turn into add strobes
  p_ignore_when_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    creditFull |-> (strobes.clear && !strobes.addNickel && !strobes.addDime));

  // R8: two coins at once must produce no strobe
  p_both_coins_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (coinNickel && coinDime && !creditFull) |-> (strobes == '0));

  // R8: the datapath never receives more than one strobe
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/vendCtrlCredit.sv
module vendCtrlCredit
  import vendCtrlPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  output logic    creditFull
);

  localparam int SUM_W = CREDIT_W + 1;
  localparam logic [SUM_W-1:0] NICKEL_STEP = SUM_W'(NICKEL_UNIT);
  localparam logic [SUM_W-1:0] DIME_STEP   = SUM_W'(DIME_UNIT);
  localparam logic [SUM_W-1:0] SUM_LIMIT   = {1'b0, CREDIT_FULL};

  credit_t          credit;
  credit_t          nextCredit;
  logic [SUM_W-1:0] step;
  logic [SUM_W-1:0] sum;

  always_comb begin
    if (strobes.addDime)        step = DIME_STEP;
    else if (strobes.addNickel) step = NICKEL_STEP;
    else                        step = '0;
    sum = {1'b0, credit} + step;
    if (strobes.clear)          nextCredit = CREDIT_ZERO;
    else if (sum > SUM_LIMIT)   nextCredit = CREDIT_FULL;   // no change returned
    else                        nextCredit = sum[CREDIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) credit <= CREDIT_ZERO;
    else       credit <= nextCredit;
  end

  assign creditFull = (credit == CREDIT_FULL);

  // R6: a clear strobe leaves zero credit behind
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (credit == CREDIT_ZERO));

  // R6: the full state never lasts two cycles
  p_full_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    creditFull |=> !creditFull);

  // R4: a dime one step below full saturates at full
  p_saturate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (credit == CREDIT_FULL - 1'b1 && strobes.addDime && !strobes.clear) |=> creditFull);

  // R9: no strobe means the credit holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(credit));

endmodule

// File: rtl/vendCtrl.sv
module vendCtrl
  import vendCtrlPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic coinNickel,
  input  logic coinDime,
  output logic vendOpen
);

  strobe_t strobes;
  logic    creditFull;

  vendCtrlFsm i_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .coinNickel(coinNickel),
    .coinDime  (coinDime),
    .creditFull(creditFull),
    .strobes   (strobes)
  );

  vendCtrlCredit i_credit (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .creditFull(creditFull)
  );

  // R5: release is decoded purely from the stored state
  assign vendOpen = creditFull;

endmodule

// File: tb/test_vendCtrl.sv
`timescale 1ns/1ps
module test_vendCtrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coinNickel = 1'b0;
  logic coinDime = 1'b0;
  logic vendOpen;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  vendCtrl i_vendCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .coinNickel(coinNickel),
    .coinDime  (coinDime),
    .vendOpen  (vendOpen)
  );

  // Each entry: {nickel, dime, expected vendOpen after the next edge}.
  localparam int NVEC = 23;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b100, // R2  0->5
    3'b000, // R9  hold 5
    3'b100, // R2  5->10
    3'b110, // R8  both: hold 10
    3'b101, // R2  10->15 release
    3'b010, // R7  dime ignored, back to 0
    3'b010, // R3  0->10
    3'b011, // R4  10+10 saturates at 15
    3'b000, // R6  back to 0
    3'b100, // R2  0->5
    3'b011, // R3  5->15
    3'b100, // R7  nickel ignored -> 0
    3'b100, // R7  only 5 now
    3'b011, // R3  5->15
    3'b110, // R7  both ignored while full -> 0
    3'b000, // R9  hold 0
    3'b010, // R3  0->10
    3'b110, // R8  hold 10
    3'b000, // R9  hold 10
    3'b101, // R2  10->15
    3'b000, // R6  back to 0
    3'b010, // R3  0->10
    3'b011  // R4  saturate
  };
  localparam int VREQ [NVEC] = '{2,9,2,8,2,7,3,4,6,2,3,7,7,3,7,9,3,8,9,2,6,3,4};

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: vendOpen=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at a falling edge, sample at the following falling edge
  task automatic coin(input logic n, input logic d, input logic exp, input string req);
    coinNickel = n;
    coinDime   = d;
    @(negedge clk);
    check(req, vendOpen, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", vendOpen, 1'b0);   // reset state
    rstN = 1'b1;
    @(negedge clk);
    check("R1", vendOpen, 1'b0);

    for (int i = 0; i < NVEC; i++)
      coin(VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R%0d", VREQ[i]));

    // Idle after a release: stays low (R5, R6)
    coin(1'b0, 1'b0, 1'b0, "R6");
    coin(1'b0, 1'b0, 1'b0, "R5");

    // R1: reset mid-purchase clears credit
    coin(1'b0, 1'b1, 1'b0, "R3");            // credit 10
    coinDime = 1'b0;
    rstN = 1'b0;
    #1;
    check("R1", vendOpen, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    coin(1'b1, 1'b0, 1'b0, "R1");            // 5, not 15
    coin(1'b0, 1'b1, 1'b1, "R1");            // 15 only now
    coin(1'b0, 1'b0, 1'b0, "R6");

    // R5: output ignores current inputs within a cycle
    coinNickel = 1'b1;
    #1;
    check("R5", vendOpen, 1'b0);
    coin(1'b1, 1'b0, 1'b0, "R2");

    coinNickel = 1'b0;
    coinDime   = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule